// File: doc/BRIEF.md
# DRAM mode register programming sequencer

This block sits in a DDR2-style memory controller and produces the single command cycle that loads the main mode register of the memory device. The controller presents the wanted settings as plain values: burst length (4 or 8), burst ordering, CAS latency, DLL reset, power-down exit speed, and the write-recovery time and clock period in picoseconds. A one-cycle request then starts the sequencer, which does the following in order:

- It turns the write-recovery time into a clock count by rounding the quotient up, using a small subtract-and-count loop.
- It validates every field.
- It drives the mode register set command with the assembled register word.

After the command, the block holds off for the mode-register command delay and then pulses done. A request is refused with an error pulse when the device is not in the all-banks-precharged state or clock enable is low. An illegal field also ends the request with an error, and in that case no command is driven. While the sequencer works, the command pins carry a NOP (chip select low, the other three strobes high).

Top module: `mrs_sequencer`

## Requirements
- R1: The mode register set command is one cycle with cs_n, ras_n, cas_n and we_n all 0 and ba all 0. In every other cycle the pins show a NOP: cs_n 0, ras_n/cas_n/we_n 1, ba 0 and addr 0.
- R2: A request seen while idle with banks_idle low or cke low gives err high for exactly the next cycle. No command is issued and busy stays low.
- R3: Burst length is placed on addr[2:0], with 4 encoded as 010 and 8 as 011. Any other requested length gives an error and no command.
- R4: addr[3] carries the burst ordering: 0 for sequential, 1 for interleaved.
- R5: CAS latency 2 to 6 is placed on addr[6:4] as its own binary value (010 to 110). Any other latency gives an error and no command.
- R6: addr[7] (test mode) is 0 in every cycle. addr[8] carries the DLL reset request.
- R7: The write-recovery count is the ceiling of twr_ps/tck_ps. It is placed on addr[11:9] as count minus one (2 gives 001, 6 gives 101). A count below 2 or above 6 is rejected, and so is tck_ps of 0; the codes 000, 110 and 111 are never driven.
- R8: addr[12] carries the power-down exit choice (0 fast, 1 slow). addr[15:13] are 0.
- R9: Let N be the write-recovery count capped at 7, with N = 7 when tck_ps is 0 and twr_ps is non-zero. The command, or the error pulse for an illegal field, appears N+1 cycles after the edge that accepts the request. Err and the command never coincide.
- R10: busy is high from the cycle after an accepted request until the lockout ends. Requests seen while busy are ignored and do not change any latched setting.
- R11: done pulses for one cycle exactly TMRD cycles after the command cycle, and busy is low in that cycle. No other command appears in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Start a mode register write (sampled when idle) |
| burst_len | input | 4 | Requested burst length, 4 or 8 |
| interleave | input | 1 | 1 selects interleaved burst order |
| cas_lat | input | 3 | Requested CAS latency in cycles |
| dll_rst | input | 1 | Request a DLL reset |
| slow_exit | input | 1 | 1 selects slow power-down exit |
| twr_ps | input | PS_W | Write recovery time in ps |
| tck_ps | input | PS_W | Clock period in ps |
| banks_idle | input | 1 | All banks are precharged |
| cke | input | 1 | Clock enable currently high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | 16 | Address bus carrying the register word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at end of lockout |
| err | output | 1 | One-cycle pulse on a refused or illegal request |

## Verification
The recovery-time ratios are chosen to land exactly on an integer, just above one, at one and at seven cycles, and with a zero clock period. These separate a correct round-up from truncation or rounding to nearest, and show where the capped loop and the error window fall. Each burst length, latency and flag setting moves a different address field, and illegal lengths and latencies appear alongside an otherwise legal recovery time, so each rejection is observed on its own. Requests are also made with banks not precharged, with clock enable low, as a second pulse during a running sequence and as a request held across several sequences. These show the precondition gate, the fields latched at acceptance and the re-acceptance right at the done cycle.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALC  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_LOCK  = 2'd3
  } mrs_state_e;

  localparam logic [2:0] BL4_CODE = 3'b010;
  localparam logic [2:0] BL8_CODE = 3'b011;
  localparam logic [2:0] LAT_LO   = 3'd2;
  localparam logic [2:0] LAT_HI   = 3'd6;

  // Register word below the three reserved top bits
  typedef struct packed {
    logic       slow_exit;
    logic [2:0] wr_code;
    logic       dll_rst;
    logic       test_mode;
    logic [2:0] cl_code;
    logic       interleave;
    logic [2:0] bl_code;
  } mode_word_t;

endpackage

// File: rtl/mrs_ceil_div.sv
module mrs_ceil_div #(
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          fin,
  output logic [CW-1:0] quot
);

  localparam logic [CW-1:0] CAP = '1;

  logic [W-1:0]  rem_q, rem_d, dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          step_en;

  assign fin     = run_q && ((rem_q == '0) || (cnt_q == CAP));
  assign quot    = cnt_q;
  assign step_en = start || run_q;

  always_comb begin
    rem_d = rem_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      rem_d = dividend;
      dvs_d = divisor;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (fin) begin
        run_d = 1'b0;
      end else begin
        rem_d = (rem_q > dvs_q) ? (rem_q - dvs_q) : '0;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (step_en) begin
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  AST_DIV_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !fin && !start && dvs_q != '0) |=> (rem_q < $past(rem_q))); // R7

  AST_DIV_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !run_q); // R9

endmodule

// File: rtl/mrs_field_encode.sv
module mrs_field_encode
  import mrs_pkg::*;
(
  input  logic [3:0]  burst_len,
  input  logic        interleave,
  input  logic [2:0]  cas_lat,
  input  logic        dll_rst,
  input  logic        slow_exit,
  input  logic [2:0]  wr_cyc,
  output mode_word_t  word,
  output logic        fields_ok
);

  logic bl_ok, cl_ok, wr_ok;

  always_comb begin
    word            = '0;
    word.interleave = interleave;
    word.dll_rst    = dll_rst;
    word.slow_exit  = slow_exit;
    word.test_mode  = 1'b0;
    bl_ok           = 1'b1;
    case (burst_len)
      4'd4:    word.bl_code = BL4_CODE;
      4'd8:    word.bl_code = BL8_CODE;
      default: bl_ok = 1'b0;
    endcase
    cl_ok = (cas_lat >= LAT_LO) && (cas_lat <= LAT_HI);
    wr_ok = (wr_cyc  >= LAT_LO) && (wr_cyc  <= LAT_HI);
    if (cl_ok) word.cl_code = cas_lat;
    if (wr_ok) word.wr_code = wr_cyc - 3'd1;
    fields_ok = bl_ok && cl_ok && wr_ok;
  end

endmodule

// File: rtl/mrs_lockout.sv
module mrs_lockout #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);

  localparam int            CNTW = (TMRD > 2) ? $clog2(TMRD - 1) : 1;
  localparam logic [CNTW-1:0] LOAD = CNTW'(TMRD - 2);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            act_q, act_d;
  logic            tick_en;

  assign expire  = act_q && (cnt_q == '0);
  assign tick_en = start || act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = LOAD;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  AST_LOCK_ONE_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !expire); // R11

endmodule

// File: rtl/mrs_sequencer.sv
module mrs_sequencer
  import mrs_pkg::*;
#(
  parameter int PS_W = 16,
  parameter int TMRD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [3:0]      burst_len,
  input  logic            interleave,
  input  logic [2:0]      cas_lat,
  input  logic            dll_rst,
  input  logic            slow_exit,
  input  logic [PS_W-1:0] twr_ps,
  input  logic [PS_W-1:0] tck_ps,
  input  logic            banks_idle,
  input  logic            cke,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [2:0]      ba,
  output logic [15:0]     addr,
  output logic            busy,
  output logic            done,
  output logic            err
);

  localparam int CW = 3;

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  mrs_state_e  state_q, state_d;
  logic        err_q, err_d, done_q, done_d;
  logic        accept, div_start, div_fin, lock_start, lock_expire, mode_ld;
  logic [CW-1:0] wr_cyc;
  logic [3:0]  bl_q;
  logic        il_q, dll_q, slow_q;
  logic [2:0]  cl_q;
  mode_word_t  word, mode_q;
  logic        fields_ok, issuing, mrs_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign accept = (state_q == ST_IDLE) && req && banks_idle && cke;

  mrs_ceil_div #(.W(PS_W), .CW(CW)) u_div (
    .clk(clk), .rst_n(rst_int_n), .start(div_start),
    .dividend(twr_ps), .divisor(tck_ps), .fin(div_fin), .quot(wr_cyc)
  );

  mrs_field_encode u_enc (
    .burst_len(bl_q), .interleave(il_q), .cas_lat(cl_q), .dll_rst(dll_q),
    .slow_exit(slow_q), .wr_cyc(wr_cyc), .word(word), .fields_ok(fields_ok)
  );

  mrs_lockout #(.TMRD(TMRD)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .start(lock_start), .expire(lock_expire)
  );

  always_comb begin
    state_d    = state_q;
    err_d      = 1'b0;
    done_d     = 1'b0;
    div_start  = 1'b0;
    lock_start = 1'b0;
    mode_ld    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          div_start = 1'b1;
          state_d   = ST_CALC;
        end else if (req) begin
          err_d = 1'b1;
        end
      end
      ST_CALC: begin
        if (div_fin) begin
          if (fields_ok) begin
            mode_ld = 1'b1;
            state_d = ST_ISSUE;
          end else begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_ISSUE: begin
        lock_start = 1'b1;
        state_d    = ST_LOCK;
      end
      ST_LOCK: begin
        if (lock_expire) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bl_q   <= '0;
      il_q   <= 1'b0;
      cl_q   <= '0;
      dll_q  <= 1'b0;
      slow_q <= 1'b0;
    end else if (accept) begin
      bl_q   <= burst_len;
      il_q   <= interleave;
      cl_q   <= cas_lat;
      dll_q  <= dll_rst;
      slow_q <= slow_exit;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mode_q <= '0;
    else if (mode_ld) mode_q <= word;
  end

  assign issuing = (state_q == ST_ISSUE);
  assign cs_n    = 1'b0;
  assign ras_n   = !issuing;
  assign cas_n   = !issuing;
  assign we_n    = !issuing;
  assign ba      = 3'b000;
  assign addr    = issuing ? {3'b000, mode_q} : 16'h0000;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;

  assign mrs_cmd = !cs_n && !ras_n && !cas_n && !we_n;

  AST_MRS_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrs_cmd |=> !mrs_cmd); // R1

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (ras_n && cas_n && we_n && addr == 16'h0000)); // R1

  AST_REFUSE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req && !busy && !(banks_idle && cke)) |=> (err && !busy)); // R2

  AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrs_cmd |-> (addr[2:0] == 3'b010 || addr[2:0] == 3'b011)); // R3

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrs_cmd |-> (addr[6:4] >= 3'd2 && addr[6:4] <= 3'd6)); // R5

  AST_WR_LEGAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrs_cmd |-> (addr[11:9] >= 3'd1 && addr[11:9] <= 3'd5)); // R7

  AST_NO_ERR_WITH_MRS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(err && mrs_cmd)); // R9

  AST_BUSY_AFTER_MRS: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrs_cmd |=> busy); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy); // R11

endmodule

// File: tb/mrs_sequencer_tb.sv
module mrs_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int B_TMRD     = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  burst_len = 4'd4;
  logic        interleave = 1'b0;
  logic [2:0]  cas_lat = 3'd3;
  logic        dll_rst = 1'b0;
  logic        slow_exit = 1'b0;
  logic [15:0] twr_ps = 16'd0;
  logic [15:0] tck_ps = 16'd1;
  logic        banks_idle = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n, ras_n, cas_n, we_n, busy, done, err;
  logic [2:0]  ba;
  logic [15:0] addr;

  mrs_sequencer #(.PS_W(16), .TMRD(B_TMRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .burst_len(burst_len),
    .interleave(interleave), .cas_lat(cas_lat), .dll_rst(dll_rst),
    .slow_exit(slow_exit), .twr_ps(twr_ps), .tck_ps(tck_ps),
    .banks_idle(banks_idle), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .busy(busy),
    .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycle    = 0;
  bit chk_en   = 0;
  bit finished = 0;

  // Reference model state
  bit          m_active = 0;
  int          m_t = 0;
  int          m_q = 0;
  bit          m_ok = 0;
  logic [15:0] m_word = '0;
  bit          exp_busy = 0, exp_done = 0, exp_err = 0, exp_mrs = 0;
  logic [15:0] exp_addr;

  function automatic logic [15:0] ref_word(int bl, bit il, int cl, bit dll,
                                           bit slow, int wr);
    logic [15:0] w;
    w       = '0;
    w[2:0]  = (bl == 8) ? 3'd3 : 3'd2;
    w[3]    = il;
    w[6:4]  = 3'(cl);
    w[8]    = dll;
    w[11:9] = 3'(wr - 1);
    w[12]   = slow;
    return w;
  endfunction

  always @(posedge clk) begin
    cycle++;
    exp_err  = 0;
    exp_done = 0;
    exp_mrs  = 0;
    if (!rst_n) begin
      m_active = 0;
    end else if (!m_active) begin
      if (req) begin
        if (banks_idle && cke) begin
          int tw, tc;
          tw = int'(twr_ps);
          tc = int'(tck_ps);
          if (tc == 0) m_q = (tw == 0) ? 0 : 7;
          else         m_q = (tw + tc - 1) / tc;
          if (m_q > 7) m_q = 7;
          m_ok = (burst_len == 4 || burst_len == 8) &&
                 (cas_lat >= 2 && cas_lat <= 6) && (m_q >= 2 && m_q <= 6);
          m_word   = ref_word(int'(burst_len), interleave, int'(cas_lat),
                              dll_rst, slow_exit, m_q);
          m_active = 1;
          m_t      = 0;
        end else begin
          exp_err = 1;
        end
      end
    end else begin
      m_t++;
      if (m_t == m_q + 1) begin
        if (m_ok) exp_mrs = 1;
        else begin
          exp_err  = 1;
          m_active = 0;
        end
      end else if (m_ok && m_t == m_q + 1 + B_TMRD) begin
        exp_done = 1;
        m_active = 0;
      end
    end
    exp_busy = m_active;
  end

  task automatic chk(input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycle, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !finished) begin
      exp_addr = exp_mrs ? m_word : 16'h0000;
      chk("R1 command pins", {12'h0, cs_n, ras_n, cas_n, we_n},
          exp_mrs ? 16'h0000 : 16'h0007);
      chk("R1 bank address", {13'h0, ba}, 16'h0000);
      chk("R3 burst length field", {13'h0, addr[2:0]}, {13'h0, exp_addr[2:0]});
      chk("R4 burst type bit", {15'h0, addr[3]}, {15'h0, exp_addr[3]});
      chk("R5 latency field", {13'h0, addr[6:4]}, {13'h0, exp_addr[6:4]});
      chk("R6 test and dll bits", {14'h0, addr[8:7]}, {14'h0, exp_addr[8:7]});
      chk("R7 write recovery field", {13'h0, addr[11:9]}, {13'h0, exp_addr[11:9]});
      chk("R8 exit and top bits", {12'h0, addr[15:12]}, {12'h0, exp_addr[15:12]});
      chk("R2/R9 error flag", {15'h0, err}, {15'h0, exp_err});
      chk("R10 busy", {15'h0, busy}, {15'h0, exp_busy});
      chk("R11 done", {15'h0, done}, {15'h0, exp_done});
    end
  end

  task automatic idle_wait();
    @(negedge clk);
    while (m_active) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_fields(input int bl, input bit il, input int cl,
                            input bit dll, input bit slow, input int twr,
                            input int tck);
    burst_len  = 4'(bl);
    interleave = il;
    cas_lat    = 3'(cl);
    dll_rst    = dll;
    slow_exit  = slow;
    twr_ps     = 16'(twr);
    tck_ps     = 16'(tck);
  endtask

  task automatic request(input int bl, input bit il, input int cl,
                         input bit dll, input bit slow, input int twr,
                         input int tck, input bit bk, input bit ck);
    @(negedge clk);
    set_fields(bl, il, cl, dll, slow, twr, tck);
    banks_idle = bk;
    cke        = ck;
    req        = 1'b1;
    @(negedge clk);
    req        = 1'b0;
    banks_idle = 1'b1;
    cke        = 1'b1;
    idle_wait();
  endtask

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    report();
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    chk_en = 1;                       // reset state is checked from here (R1)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    request(4, 0, 3, 1, 0, 15000, 3750, 1, 1);   // R3 R6 R7: 4 cycles
    request(8, 1, 5, 0, 1, 15000, 2500, 1, 1);   // R4 R8: 6 cycles
    request(4, 1, 2, 1, 1, 5000, 2500, 1, 1);    // R5 R7: exactly 2
    request(8, 0, 6, 0, 0, 3000, 2500, 1, 1);    // R7: rounds up to 2
    request(4, 0, 4, 0, 0, 2500, 2500, 1, 1);    // R7: 1 cycle rejected
    request(4, 0, 4, 0, 0, 15001, 2500, 1, 1);   // R7: 7 cycles rejected
    request(4, 0, 4, 0, 0, 60000, 1000, 1, 1);   // R9: capped loop
    request(4, 0, 4, 0, 0, 15000, 0, 1, 1);      // R7: zero period
    request(16, 0, 4, 0, 0, 7500, 2500, 1, 1);   // R3: bad length
    request(2, 0, 4, 0, 0, 7500, 2500, 1, 1);    // R3: bad length
    request(8, 0, 7, 0, 0, 7500, 2500, 1, 1);    // R5: latency 7
    request(8, 0, 1, 0, 0, 7500, 2500, 1, 1);    // R5: latency 1
    request(8, 0, 3, 0, 0, 7500, 2500, 0, 1);    // R2: banks open
    request(8, 0, 3, 0, 0, 7500, 2500, 1, 0);    // R2: cke low

    // R10: second request during a running sequence is ignored
    @(negedge clk);
    set_fields(8, 1, 4, 1, 0, 12500, 2500);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    set_fields(4, 0, 2, 0, 1, 5000, 2500);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    idle_wait();

    // R11: request held high is re-accepted right at the done cycle
    @(negedge clk);
    set_fields(4, 1, 6, 0, 1, 7000, 2500);
    req = 1'b1;
    repeat (30) @(negedge clk);
    req = 1'b0;
    idle_wait();

    repeat (4) @(negedge clk);
    report();
  end

endmodule